// File: doc/BRIEF.md
# Predicate Interleave Permute Unit

This unit rearranges the bits of two source predicate registers of a scalable vector machine into one destination predicate. A 3-bit operation code picks one of six permutes: zip of the low halves, zip of the high halves, unzip keeping even elements, unzip keeping odd elements, transpose of even elements and transpose of odd elements. A 2-bit element-size code groups the predicate into elements of 1, 2, 4 or 8 bits. The active predicate length is set at run time in steps of 16 bits, up to the parameter `MAX_PBITS`. The length need not be a power of two, so the half-way point used by the zip and unzip operations can fall on any multiple of 8 bits.

A request is presented with `in_valid`. The destination predicate appears on `out_pred` one clock later, with `out_valid` high. A two-state machine tracks whether a result is held. `ST_IDLE` moves to `ST_RESULT` on `in_valid` and otherwise stays put. `ST_RESULT` returns to `ST_IDLE` when `in_valid` is low and stays in `ST_RESULT` when it is high. Reset forces `ST_IDLE`.

A separate combinational decoder splits a 32-bit instruction word of this permute group into operation, element size and three register numbers. It reports whether the word belongs to the group.

Top module: `pperm_unit`

## Requirements
- R1: Zip low (op 000) takes elements 0..h-1 of each source, where h is half the active element count. First-source element i goes to destination element 2i, and second-source element i goes to element 2i+1.
- R2: Zip high (op 001) does the same using source elements h..2h-1. The half point is exact at any active length, including lengths whose half is not a multiple of 32 bits (for example 48 bits).
- R3: Unzip (op 010 even, op 011 odd) puts element 2i (even) or 2i+1 (odd) of the first source into destination element i, and the same element of the second source into destination element h+i.
- R4: Transpose (op 100 even, op 101 odd) puts element 2i (even) or 2i+1 (odd) of the first source into destination element 2i, and the same element of the second source into destination element 2i+1.
- R5: Element size code e (in_esz) makes each element 2^e bits wide: code 0 gives 1 bit, 1 gives 2, 2 gives 4 and 3 gives 8. Elements are packed from bit 0 upward.
- R6: Destination bits at or above the active length L are zero. Source bits at or above L have no effect on the result.
- R7: The active length is L = 16 × in_len bits. A length code of 0 acts as 1 (L = 16), and codes above MAX_PBITS/16 act as MAX_PBITS/16.
- R8: Op codes 110 and 111 give an all-zero destination.
- R9: out_valid is high exactly in the cycle after a cycle with in_valid high. The result of that request is on out_pred in that cycle. Synchronous active-high reset clears out_valid and out_pred.
- R10: For a claimed word, the decoder takes the element size from bits 23:22, the operation from 12:10, the second source from 19:16, the first source from 8:5 and the destination from 3:0.
- R11: The decoder claims a word only if all of the following hold: bits 31:24 = 00000101, bits 21:20 = 10, bits 15:13 = 010, bit 9 = 0, bit 4 = 0, and bits 12:10 are 101 or below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_op | input | 3 | Permute operation code |
| in_esz | input | 2 | Element size code |
| in_len | input | $clog2(MAX_PBITS/16)+1 | Active length in 16-bit units |
| in_src_n | input | MAX_PBITS | First source predicate |
| in_src_m | input | MAX_PBITS | Second source predicate |
| out_valid | output | 1 | Result strobe |
| out_pred | output | MAX_PBITS | Destination predicate |
| dec_insn | input | 32 | Instruction word to decode |
| dec_hit | output | 1 | Word belongs to this group |
| dec_op | output | 3 | Decoded operation |
| dec_esz | output | 2 | Decoded element size |
| dec_rd | output | 4 | Destination register number |
| dec_rn | output | 4 | First source register number |
| dec_rm | output | 4 | Second source register number |

## Verification
A wrong state in the machine shows up one cycle after the strobe. It appears either as a missing `out_valid` after a request or as a spurious one after an idle cycle. Back-to-back requests separated by gaps expose both cases. A wrong bit index in the permute network changes `out_pred` in the same result cycle. Such errors usually show only for some element sizes or lengths, so every operation is run at several sizes. The lengths used include ones with a half point that is not a multiple of 32 bits, and junk is placed above the active length in the sources.

// File: rtl/pperm_pkg.sv
package pperm_pkg;

    typedef enum logic [2:0] {
        OP_ZIP_LO  = 3'b000,
        OP_ZIP_HI  = 3'b001,
        OP_UZP_EV  = 3'b010,
        OP_UZP_OD  = 3'b011,
        OP_TRN_EV  = 3'b100,
        OP_TRN_OD  = 3'b101,
        OP_RSV6    = 3'b110,
        OP_RSV7    = 3'b111
    } pperm_op_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_RESULT = 1'b1
    } pperm_state_e;

    typedef struct packed {
        logic      hit;
        logic [2:0] op;
        logic [1:0] esz;
        logic [3:0] rd;
        logic [3:0] rn;
        logic [3:0] rm;
    } pperm_dec_t;

endpackage

// File: rtl/pperm_decode.sv
module pperm_decode
    import pperm_pkg::*;
(
    input  logic [31:0] insn,
    output pperm_dec_t  dec
);
    logic fixed_ok;
    logic op_ok;

    always_comb begin
        fixed_ok = (insn[31:24] == 8'b0000_0101) &&
                   (insn[21:20] == 2'b10)        &&
                   (insn[15:13] == 3'b010)       &&
                   (insn[9] == 1'b0)             &&
                   (insn[4] == 1'b0);
        op_ok    = (insn[12:11] != 2'b11);
        dec.hit  = fixed_ok && op_ok;
        dec.op   = insn[12:10];
        dec.esz  = insn[23:22];
        dec.rm   = insn[19:16];
        dec.rn   = insn[8:5];
        dec.rd   = insn[3:0];
    end
endmodule

// File: rtl/pperm_core.sv
module pperm_core
    import pperm_pkg::*;
#(
    parameter int MAX_PBITS = 256,
    parameter int LEN_W     = $clog2(MAX_PBITS/16) + 1
) (
    input  logic [MAX_PBITS-1:0] src_n,
    input  logic [MAX_PBITS-1:0] src_m,
    input  pperm_op_e            op,
    input  logic [1:0]           esz,
    input  logic [LEN_W-1:0]     len,
    output logic [MAX_PBITS-1:0] res
);
    localparam int MAX_UNITS = MAX_PBITS / 16;
    localparam int AW        = $clog2(MAX_PBITS);

    int act_bits;
    int half_bits;
    int elem_bits;

    always_comb begin
        int units;
        units = int'(len);
        if (units == 0)        units = 1;
        if (units > MAX_UNITS) units = MAX_UNITS;
        act_bits  = units * 16;
        half_bits = act_bits / 2;
        elem_bits = 1 << esz;
    end

    always_comb begin
        res = '0;
        for (int j = 0; j < MAX_PBITS; j++) begin
            int k;
            int b;
            int idx;
            int jj;
            int odd_off;
            logic use_m;
            logic live;
            k       = j >> esz;
            b       = j & (elem_bits - 1);
            odd_off = op[0] ? elem_bits : 0;
            idx     = 0;
            jj      = 0;
            use_m   = 1'b0;
            live    = 1'b1;
            unique case (op)
                OP_ZIP_LO, OP_ZIP_HI: begin
                    use_m = k[0];
                    idx   = (op[0] ? half_bits : 0) + ((j >> (esz + 1)) << esz) + b;
                end
                OP_UZP_EV, OP_UZP_OD: begin
                    if (j < half_bits) begin
                        jj    = j;
                        use_m = 1'b0;
                    end else begin
                        jj    = j - half_bits;
                        use_m = 1'b1;
                    end
                    idx = ((jj >> esz) << (esz + 1)) + odd_off + b;
                end
                OP_TRN_EV, OP_TRN_OD: begin
                    use_m = k[0];
                    idx   = ((k & 32'hFFFF_FFFE) << esz) + odd_off + b;
                end
                OP_RSV6, OP_RSV7: begin
                    live = 1'b0;
                end
            endcase
            if (live && (j < act_bits) && (idx < act_bits)) begin
                res[j] = use_m ? src_m[AW'(idx)] : src_n[AW'(idx)];
            end
        end
    end
endmodule

// File: rtl/pperm_unit.sv
module pperm_unit
    import pperm_pkg::*;
#(
    parameter int MAX_PBITS = 256,
    parameter int LEN_W     = $clog2(MAX_PBITS/16) + 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [2:0]           in_op,
    input  logic [1:0]           in_esz,
    input  logic [LEN_W-1:0]     in_len,
    input  logic [MAX_PBITS-1:0] in_src_n,
    input  logic [MAX_PBITS-1:0] in_src_m,
    output logic                 out_valid,
    output logic [MAX_PBITS-1:0] out_pred,
    input  logic [31:0]          dec_insn,
    output logic                 dec_hit,
    output logic [2:0]           dec_op,
    output logic [1:0]           dec_esz,
    output logic [3:0]           dec_rd,
    output logic [3:0]           dec_rn,
    output logic [3:0]           dec_rm
);
    localparam int MAX_UNITS = MAX_PBITS / 16;

    pperm_state_e         state_q;
    pperm_state_e         state_d;
    logic [MAX_PBITS-1:0] perm_res;
    pperm_dec_t           dec;

    pperm_core #(
        .MAX_PBITS (MAX_PBITS),
        .LEN_W     (LEN_W)
    ) u_core (
        .src_n (in_src_n),
        .src_m (in_src_m),
        .op    (pperm_op_e'(in_op)),
        .esz   (in_esz),
        .len   (in_len),
        .res   (perm_res)
    );

    pperm_decode u_dec (
        .insn (dec_insn),
        .dec  (dec)
    );

    assign dec_hit = dec.hit;
    assign dec_op  = dec.op;
    assign dec_esz = dec.esz;
    assign dec_rd  = dec.rd;
    assign dec_rn  = dec.rn;
    assign dec_rm  = dec.rm;

    always_comb begin
        unique case (state_q)
            ST_IDLE:   state_d = in_valid ? ST_RESULT : ST_IDLE;
            ST_RESULT: state_d = in_valid ? ST_RESULT : ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst)           out_pred <= '0;
        else if (in_valid) out_pred <= perm_res;
    end

    assign out_valid = (state_q == ST_RESULT);

    int len_bits_now;
    always_comb begin
        int u;
        u = int'(in_len);
        if (u == 0)         u = 1;
        if (u > MAX_UNITS)  u = MAX_UNITS;
        len_bits_now = u * 16;
    end

    // R9
    valid_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R9
    no_spurious_valid_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R6
    tail_zero_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> ((out_pred >> $past(len_bits_now)) == '0));

    // R8
    reserved_op_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (in_op[2:1] == 2'b11)) |=> (out_pred == '0));

    // R11
    claimed_op_range_chk: assert property (@(posedge clk) disable iff (rst)
        dec_hit |-> (dec_op <= 3'd5 && dec_insn[4] == 1'b0));
endmodule

// File: tb/pperm_unit_bench.sv
module pperm_unit_bench;
    localparam int CLK_PERIOD = 10;
    localparam int P          = 256;
    localparam int LW         = $clog2(P/16) + 1;

    typedef struct {
        logic [P-1:0] exp;
        string        tag;
    } item_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [2:0]   in_op = '0;
    logic [1:0]   in_esz = '0;
    logic [LW-1:0] in_len = '0;
    logic [P-1:0] in_src_n = '0;
    logic [P-1:0] in_src_m = '0;
    logic         out_valid;
    logic [P-1:0] out_pred;
    logic [31:0]  dec_insn = '0;
    logic         dec_hit;
    logic [2:0]   dec_op;
    logic [1:0]   dec_esz;
    logic [3:0]   dec_rd, dec_rn, dec_rm;

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    finished = 1'b0;
    item_t sb[$];

    pperm_unit #(.MAX_PBITS(P)) u_pperm_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op), .in_esz(in_esz),
        .in_len(in_len), .in_src_n(in_src_n), .in_src_m(in_src_m),
        .out_valid(out_valid), .out_pred(out_pred), .dec_insn(dec_insn),
        .dec_hit(dec_hit), .dec_op(dec_op), .dec_esz(dec_esz),
        .dec_rd(dec_rd), .dec_rn(dec_rn), .dec_rm(dec_rm)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [P-1:0] ref_perm(input logic [P-1:0] n, input logic [P-1:0] m,
                                               input logic [2:0] op, input logic [1:0] esz,
                                               input int lenu);
        int u;
        int L;
        int E;
        int he;
        int odd;
        logic [P-1:0] d;
        u   = (lenu == 0) ? 1 : ((lenu > P/16) ? P/16 : lenu);
        L   = 16 * u;
        E   = 1 << esz;
        he  = (L / E) / 2;
        odd = int'(op[0]);
        d   = '0;
        for (int e = 0; e < he; e++) begin
            for (int b = 0; b < E; b++) begin
                case (op[2:1])
                    2'd0: begin
                        d[2*e*E+b]     = n[(odd*he+e)*E+b];
                        d[(2*e+1)*E+b] = m[(odd*he+e)*E+b];
                    end
                    2'd1: begin
                        d[e*E+b]      = n[(2*e+odd)*E+b];
                        d[(he+e)*E+b] = m[(2*e+odd)*E+b];
                    end
                    2'd2: begin
                        d[2*e*E+b]     = n[(2*e+odd)*E+b];
                        d[(2*e+1)*E+b] = m[(2*e+odd)*E+b];
                    end
                    default: ;
                endcase
            end
        end
        return d;
    endfunction

    function automatic logic [P-1:0] rnd_pred();
        logic [P-1:0] v;
        for (int i = 0; i < P/32; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [P-1:0] act, input logic [P-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [P-1:0] n, input logic [P-1:0] m, input logic [2:0] op,
                        input logic [1:0] esz, input int lenu, input string tag);
        item_t it;
        in_valid = 1'b1;
        in_src_n = n;
        in_src_m = m;
        in_op    = op;
        in_esz   = esz;
        in_len   = LW'(lenu);
        it.exp   = ref_perm(n, m, op, esz, lenu);
        it.tag   = tag;
        sb.push_back(it);
        @(negedge clk);
    endtask

    task automatic send_exp(input logic [P-1:0] n, input logic [P-1:0] m, input logic [2:0] op,
                            input logic [1:0] esz, input int lenu, input logic [P-1:0] exp,
                            input string tag);
        item_t it;
        in_valid = 1'b1;
        in_src_n = n;
        in_src_m = m;
        in_op    = op;
        in_esz   = esz;
        in_len   = LW'(lenu);
        it.exp   = exp;
        it.tag   = tag;
        sb.push_back(it);
        @(negedge clk);
    endtask

    task automatic idle();
        in_valid = 1'b0;
        in_src_n = rnd_pred();
        @(negedge clk);
    endtask

    // monitor: samples one time unit after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (!rst && out_valid) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R9 unexpected out_valid", {P{1'b0}}, {P{1'b0}});
                end else begin
                    item_t it;
                    it = sb.pop_front();
                    check(out_pred === it.exp, it.tag, out_pred, it.exp);
                end
            end
        end
    end

    function automatic logic [31:0] mk_word(input logic [1:0] esz, input logic [3:0] rm,
                                            input logic [2:0] op, input logic [3:0] rn,
                                            input logic [3:0] rd);
        return {8'b0000_0101, esz, 2'b10, rm, 3'b010, op, 1'b0, rn, 1'b0, rd};
    endfunction

    task automatic dec_check(input logic [31:0] w, input bit exp_hit, input string tag);
        dec_insn = w;
        #1;
        n_checks++;
        if (dec_hit !== exp_hit ||
            (exp_hit && (dec_op !== w[12:10] || dec_esz !== w[23:22] || dec_rm !== w[19:16] ||
                         dec_rn !== w[8:5] || dec_rd !== w[3:0]))) begin
            n_fail++;
            $display("FAIL %s actual hit=%0b op=%0d esz=%0d rd=%0d rn=%0d rm=%0d expected hit=%0b op=%0d esz=%0d rd=%0d rn=%0d rm=%0d",
                     tag, dec_hit, dec_op, dec_esz, dec_rd, dec_rn, dec_rm,
                     exp_hit, w[12:10], w[23:22], w[3:0], w[8:5], w[19:16]);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog R9 actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [P-1:0] a;
        logic [P-1:0] c;
        logic [P-1:0] lit;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        check(out_valid === 1'b0 && out_pred === '0, "R9 reset", out_pred, '0);

        // R1 literal: first source all ones in low 8 bits, L=16 -> even bits set
        lit = '0;
        lit[15:0] = 16'h5555;
        send_exp({{(P-16){1'b0}}, 16'h00FF}, '0, 3'b000, 2'd0, 1, lit, "R1 zip low literal");
        idle();
        // R9 no strobe after an idle cycle
        check(out_valid === 1'b0, "R9 idle gap", {{(P-1){1'b0}}, out_valid}, '0);

        // main sweep: every op, every size, several lengths, back to back
        for (int op = 0; op < 6; op++) begin
            for (int esz = 0; esz < 4; esz++) begin
                a = rnd_pred();
                c = rnd_pred();
                case (op)
                    0: send(a, c, 3'(op), 2'(esz), 16, "R1 R5 zip low full");
                    1: send(a, c, 3'(op), 2'(esz), 16, "R2 R5 zip high full");
                    2, 3: send(a, c, 3'(op), 2'(esz), 16, "R3 R5 unzip full");
                    default: send(a, c, 3'(op), 2'(esz), 16, "R4 R5 transpose full");
                endcase
                send(a, c, 3'(op), 2'(esz), 3, "R2 R3 R4 R6 length 48 odd half");
                send(a, c, 3'(op), 2'(esz), 5, "R2 R6 length 80");
            end
            idle();
        end

        // R2 exact half at 48 bits with 8-bit elements
        send(rnd_pred(), rnd_pred(), 3'b001, 2'd3, 3, "R2 zip high L48 esz3");
        // R6 junk above length must not leak
        a = rnd_pred();
        c = rnd_pred();
        send(a, c, 3'b011, 2'd1, 2, "R6 unzip odd with junk above L");
        send({P{1'b1}}, {P{1'b1}}, 3'b100, 2'd0, 1, "R6 all ones L16");
        // R7 length code 0 and over max
        send(rnd_pred(), rnd_pred(), 3'b000, 2'd2, 0, "R7 length code zero");
        send(rnd_pred(), rnd_pred(), 3'b010, 2'd0, 17, "R7 length above max");
        send(rnd_pred(), rnd_pred(), 3'b101, 2'd3, 31, "R7 length max code");
        // R8 reserved op codes
        send_exp({P{1'b1}}, {P{1'b1}}, 3'b110, 2'd0, 16, '0, "R8 op 110");
        send_exp({P{1'b1}}, {P{1'b1}}, 3'b111, 2'd2, 16, '0, "R8 op 111");
        idle();
        idle();

        // R10 field extraction
        dec_check(mk_word(2'd2, 4'd9, 3'b011, 4'd5, 4'd12), 1'b1, "R10 unzip odd fields");
        dec_check(mk_word(2'd0, 4'd15, 3'b000, 4'd0, 4'd7), 1'b1, "R10 zip low fields");
        dec_check(mk_word(2'd3, 4'd1, 3'b101, 4'd14, 4'd2), 1'b1, "R10 transpose odd fields");
        // R11 rejections
        dec_check(mk_word(2'd1, 4'd3, 3'b110, 4'd4, 4'd5), 1'b0, "R11 op 110 rejected");
        dec_check(mk_word(2'd1, 4'd3, 3'b000, 4'd4, 4'd5) | 32'h0000_0200, 1'b0, "R11 bit9 set");
        dec_check(mk_word(2'd1, 4'd3, 3'b000, 4'd4, 4'd5) | 32'h0000_0010, 1'b0, "R11 bit4 set");
        dec_check(mk_word(2'd1, 4'd3, 3'b000, 4'd4, 4'd5) ^ 32'h0010_0000, 1'b0, "R11 bits21:20 wrong");
        dec_check(mk_word(2'd1, 4'd3, 3'b000, 4'd4, 4'd5) ^ 32'h0000_8000, 1'b0, "R11 bits15:13 wrong");
        dec_check(mk_word(2'd1, 4'd3, 3'b000, 4'd4, 4'd5) ^ 32'h0100_0000, 1'b0, "R11 top byte wrong");

        repeat (3) @(negedge clk);
        n_checks++;
        if (sb.size() != 0) begin
            n_fail++;
            $display("FAIL R9 missing results actual=%0d expected=0", sb.size());
        end
        finish_run();
    end
endmodule